// File: doc/BRIEF.md
# Clock-Generator Configuration Serial Slave

This block is an I2C slave that keeps six 8-bit configuration bytes for a clock generator and presents them in parallel on `cfg_o`. It has no register pointer. A write transfer always fills bytes from index 0 upward. A read transfer always returns a length byte and then every configuration byte in order. The bus lines are oversampled by the system clock. The slave pulls SDA low through an open-drain enable and never holds SCL low.

During reset the block captures a 4-bit strap value, which sets the power-up frequency selection. Setting bit 3 of byte 0 makes the frequency selection follow the register bits instead of the straps. The block decodes this one field of byte 0 itself. The clock-generation logic downstream decodes the rest of the configuration.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave ACKs only address byte 0xD2 (write) or 0xD3 (read), that is 7-bit address 0x69 followed by the R/W bit. For any other address it leaves SDA released for the rest of the transfer and changes no register until the next START.
- R2: In a write transfer the two bytes after the address are each ACKed and then discarded. Every later byte is ACKed and stored in byte 0, then byte 1, and so on upward.
- R3: When a STOP follows any complete byte, the bytes written so far keep their new values and all other bytes keep their old ones. Data bytes beyond byte 5 are ACKed and discarded.
- R4: A read transfer returns the length byte 6 and then bytes 0 to 5, MSB first. Any byte the host reads after byte 5 returns 0xFF.
- R5: A host NACK on any read byte makes the slave release SDA and stay released until the next START.
- R6: After reset, byte 0 is 0x00 and bytes 1 to 5 are 0xFF. Byte i appears on `cfg_o[8*i+7:8*i]`.
- R7: The straps are captured while `rst_ni` is low, and later strap changes have no effect. When byte 0 bit 3 is 0, `freq_sel_o` equals the captured straps. When it is 1, `freq_sel_o` is {byte0[6:4], byte0[2]}.
- R8: `cfg_o` changes only right after a data byte has been fully received. A partly shifted byte never appears on it.
- R9: A repeated START at any point restarts address reception, so a write transfer can be turned into a read transfer without a STOP.
- R10: `sda_oe_o` (1 = pull SDA low) changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset; straps are captured while it is low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 4 | Power-up frequency straps |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| cfg_o | output | 48 | Configuration bytes 0 to 5, byte i at bits 8*i+7:8*i |
| freq_sel_o | output | 4 | Effective frequency selection |

## Verification
The case that needs care is a register commit that falls in the same cycle as the slave starting to drive SDA for the ACK. One SCL falling edge closes the data byte, updates `cfg_o` and pulls SDA low. A behavioural byte model in the bench is compared with `cfg_o` and `freq_sel_o` on every clock, except in a short window after each eighth data bit. That window is where R8 permits the commit. The bench also forces an address restart to overlap a write in progress by issuing a repeated START straight after the command byte.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int FSEL_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } i2c_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // SDA moving while SCL is held high marks START or STOP
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           waddr_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  input  logic [FSEL_W-1:0]          strap_i,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output logic [FSEL_W-1:0]          freq_sel_o
);
  logic [FSEL_W-1:0] strap_q;

  // captured continuously while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strap_q <= strap_i;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] RST_VAL = (g == 0) ? 8'h00 : 8'hFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[g*BYTE_W +: BYTE_W] <= RST_VAL;
      else if (we_i && int'(waddr_i) == g) regs_o[g*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  assign freq_sel_o = regs_o[3] ? {regs_o[6:4], regs_o[2]} : strap_q;

  assert_strap_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(strap_q));
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter int          NUM_REGS    = 6,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [FSEL_W-1:0]          strap_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o,
  output logic [FSEL_W-1:0]          freq_sel_o
);
  localparam int                IDX_W     = $clog2(NUM_REGS + 1);
  localparam int                HDR_BYTES = 2;
  localparam logic [BYTE_W-1:0] LEN_BYTE  = BYTE_W'(NUM_REGS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_st_e           st_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wdata_q, rd_next;
  logic [IDX_W-1:0]  widx_q, ridx_q, waddr_q;
  logic [1:0]        hdr_q;
  logic              rw_q, nack_q, we_q, oe_q;

  cfg_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .we_i(we_q), .waddr_i(waddr_q), .wdata_i(wdata_q),
    .strap_i, .regs_o(cfg_o), .freq_sel_o
  );

  always_comb begin
    rd_next = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(ridx_q) == i) rd_next = cfg_o[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      widx_q  <= '0;
      ridx_q  <= '0;
      waddr_q <= '0;
      hdr_q   <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_q <= sh_q[0];
                  oe_q <= 1'b1;
                  st_q <= ST_ADDR_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                oe_q <= 1'b1;
                st_q <= ST_WR_ACK;
                if (hdr_q < 2'(HDR_BYTES)) begin
                  hdr_q <= hdr_q + 2'd1;
                end else if (int'(widx_q) < NUM_REGS) begin
                  we_q    <= 1'b1;
                  waddr_q <= widx_q;
                  wdata_q <= sh_q;
                  widx_q  <= widx_q + 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q   <= LEN_BYTE;
              oe_q   <= ~LEN_BYTE[7];
              ridx_q <= '0;
              st_q   <= ST_RD_BYTE;
            end else begin
              oe_q   <= 1'b0;
              hdr_q  <= '0;
              widx_q <= '0;
              st_q   <= ST_WR_BYTE;
            end
          end
          ST_WR_ACK: if (scl_fall) begin
            oe_q <= 1'b0;
            st_q <= ST_WR_BYTE;
          end
          ST_RD_BYTE: if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_q <= 1'b0;
              st_q <= ST_RD_ACK;
            end else begin
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) nack_q <= sda_s;
            else if (scl_fall) begin
              if (nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                tx_q  <= rd_next;
                oe_q  <= ~rd_next[7];
                cnt_q <= '0;
                if (int'(ridx_q) < NUM_REGS) ridx_q <= ridx_q + 1'b1;
                st_q  <= ST_RD_BYTE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;

  assert_addr_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && scl_fall && cnt_q == 4'd8 && sh_q[7:1] != DEV_ADDR && !start_det && !stop_det)
    |=> (st_q == ST_IDLE && !sda_oe_o));

  assert_nack_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD_ACK && scl_fall && nack_q && !start_det && !stop_det)
    |=> (st_q == ST_IDLE && !sda_oe_o));

  assert_cfg_commit_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(we_q));

  assert_oe_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));
endmodule

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb_top;
  localparam int Q = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl_h = 1'b1, sda_h = 1'b1;
  logic [3:0]  strap_i = 4'b1010;
  logic        sda_oe_o;
  logic [47:0] cfg_o;
  logic [3:0]  freq_sel_o;
  wire         sda_bus = sda_h & ~sda_oe_o;

  int checks = 0, fails = 0;
  bit settle = 1'b0, done = 1'b0;
  logic [7:0] exp_reg [6];
  logic [3:0] strap_cap = 4'b1010;
  logic       prev_oe = 1'b0;

  always #2 clk_i = ~clk_i;

  cfg_i2c_slave dut_i (
    .clk_i, .rst_ni, .scl_i(scl_h), .sda_i(sda_bus), .strap_i,
    .sda_oe_o, .cfg_o, .freq_sel_o
  );

  function automatic logic [47:0] exp_vec();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = exp_reg[i];
    return v;
  endfunction

  function automatic logic [3:0] exp_fsel();
    return exp_reg[0][3] ? {exp_reg[0][6:4], exp_reg[0][2]} : strap_cap;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference comparison every clock, outside the byte commit window (R8, R7)
  always @(negedge clk_i) begin
    if (settle && rst_ni) begin
      checks++;
      if (cfg_o !== exp_vec() || freq_sel_o !== exp_fsel()) begin
        fails++;
        if (fails < 20)
          $display("FAIL R8/R7 per-cycle: actual %h/%h expected %h/%h",
                   cfg_o, freq_sel_o, exp_vec(), exp_fsel());
      end
    end
    if (rst_ni && sda_oe_o !== prev_oe) begin
      checks++;
      if (scl_h !== 1'b0) begin
        fails++;
        $display("FAIL R10: sda_oe changed with scl actual %b expected 0", scl_h);
      end
    end
    prev_oe = sda_oe_o;
  end

  task automatic wq(input int n); repeat (n) @(negedge clk_i); endtask

  task automatic bus_start();
    sda_h = 1'b1; wq(Q); scl_h = 1'b1; wq(Q); sda_h = 1'b0; wq(Q); scl_h = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(Q); scl_h = 1'b1; wq(Q); sda_h = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int widx, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq(Q); scl_h = 1'b1; wq(2*Q); scl_h = 1'b0;
      if (i == 0) settle = 1'b0;
      wq(Q);
    end
    if (widx >= 0 && widx < 6) exp_reg[widx] = b;
    settle = 1'b1;
    sda_h = 1'b1; wq(Q); scl_h = 1'b1; wq(Q);
    acked = ~sda_bus;
    wq(Q); scl_h = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] v);
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl_h = 1'b1; wq(Q); v = {v[6:0], sda_bus}; wq(Q); scl_h = 1'b0;
    end
    wq(Q);
    sda_h = ack ? 1'b0 : 1'b1; wq(Q); scl_h = 1'b1; wq(2*Q); scl_h = 1'b0; wq(Q);
    sda_h = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit a;
    logic [7:0] v;
    logic [7:0] wr [6] = '{8'h5C, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    exp_reg = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    wq(5);
    rst_ni = 1'b1;
    wq(3);
    chk("R6 reset cfg", 64'(cfg_o), 64'hFFFF_FFFF_FF00);
    chk("R6 reset fsel", 64'(freq_sel_o), 64'hA);
    settle = 1'b1;
    strap_i = 4'b0101;
    wq(5);
    chk("R7 strap ignored after reset", 64'(freq_sel_o), 64'hA);

    // full block write plus one byte past the end
    bus_start();
    send_byte(8'hD2, -1, a); chk("R1 write addr ack", 64'(a), 64'd1);
    send_byte(8'h77, -1, a); chk("R2 command ack", 64'(a), 64'd1);
    send_byte(8'h06, -1, a); chk("R2 count ack", 64'(a), 64'd1);
    for (int i = 0; i < 6; i++) begin
      send_byte(wr[i], i, a); chk("R2 data ack", 64'(a), 64'd1);
    end
    send_byte(8'h99, -1, a); chk("R3 extra byte ack", 64'(a), 64'd1);
    bus_stop();
    chk("R2 cfg after write", 64'(cfg_o), 64'h5544_3322_115C);
    chk("R7 fsel from reg", 64'(freq_sel_o), 64'hB);

    // partial write stopped after two data bytes
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h08, 0, a);
    send_byte(8'hA7, 1, a);
    bus_stop();
    chk("R3 partial write", 64'(cfg_o), 64'h5544_3322_A708);
    chk("R7 fsel reg zero", 64'(freq_sel_o), 64'h0);

    // block read, two bytes past the end, last one NACKed
    bus_start();
    send_byte(8'hD3, -1, a); chk("R1 read addr ack", 64'(a), 64'd1);
    recv_byte(1'b1, v); chk("R4 length byte", 64'(v), 64'd6);
    for (int i = 0; i < 6; i++) begin
      recv_byte(1'b1, v); chk("R4 read data", 64'(v), 64'(exp_reg[i]));
    end
    recv_byte(1'b1, v); chk("R4 past end", 64'(v), 64'hFF);
    recv_byte(1'b0, v); chk("R4 past end nack", 64'(v), 64'hFF);
    wq(2*Q); chk("R5 released after nack", 64'(sda_oe_o), 64'd0);
    scl_h = 1'b1; wq(Q); scl_h = 1'b0; wq(Q);
    chk("R5 stays released", 64'(sda_oe_o), 64'd0);
    bus_stop();

    // foreign address
    bus_start();
    send_byte(8'hA0, -1, a); chk("R1 foreign addr nack", 64'(a), 64'd0);
    send_byte(8'h12, -1, a); chk("R1 ignored byte", 64'(a), 64'd0);
    send_byte(8'h34, -1, a);
    bus_stop();
    chk("R1 cfg unchanged", 64'(cfg_o), 64'h5544_3322_A708);

    // write turned into read by repeated start
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    bus_start();
    send_byte(8'hD3, -1, a); chk("R9 restart addr ack", 64'(a), 64'd1);
    recv_byte(1'b1, v); chk("R9 length after restart", 64'(v), 64'd6);
    recv_byte(1'b0, v); chk("R9 byte0 after restart", 64'(v), 64'h08);
    wq(2*Q); chk("R5 early nack release", 64'(sda_oe_o), 64'd0);
    bus_stop();
    chk("R9 cfg unchanged", 64'(cfg_o), 64'h5544_3322_A708);

    wq(10);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule